// File: doc/BRIEF.md
# Auto-Ranging One-Shot Delay Timer

This block times a single delay given in microseconds. Its clock runs at sixteen cycles per microsecond. When a request is accepted, the block picks a power-of-two prescale so that the scaled delay fits a 16-bit compare value. It clears its prescaler and count, and then counts scaled ticks until the count reaches the compare value. At that point it pulses `done` and goes idle.

A run can be stopped early with `abort`. The block then pulses `stopped` and reports the time spent so far, converted back to microseconds by undoing the extra scaling.

Requests arrive on a valid/ready pair:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is low for the whole of a run, so a request made during a run is simply not taken. The requester may hold `req_valid` until it is taken.
- The result side has no back-pressure. `elapsed_us` is a held register, and a one-cycle `done` or `stopped` pulse marks each update.

Top module: `autorange_oneshot`

## Requirements
- R1: After reset, `busy`, `done` and `stopped` are 0, `elapsed_us` is 0 and `req_ready` is 1.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` equals the inverse of `busy`, and a request made while busy has no effect on the running delay or its end time.
- R3: For a request d, the extra scale s is the smallest value from 0 to 11 for which d >> s is at most 65535. The count then advances once every 2^(4+s) clock cycles, so the tick is 1 µs when s is 0.
- R4: For a nonzero compare value c = d >> s, `done` goes high and `busy` goes low exactly c * 2^(4+s) clock edges after the accepting edge.
- R5: A request of 0 completes on the first clock edge after the accepting edge, without counting.
- R6: When d >> 11 exceeds 65535, s stays at 11 and the compare value saturates at 65535.
- R7: An `abort` seen while busy ends the run on that edge. It pulses `stopped` rather than `done`, and sets `elapsed_us` to the current scaled count multiplied by 2^s. If the abort and the compare match fall on the same edge, the abort wins.
- R8: An `abort` while idle has no effect: `stopped` stays 0 and `elapsed_us` keeps its value.
- R9: On a compare match, `elapsed_us` is set to c * 2^s.
- R10: `done` and `stopped` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, 16 cycles per microsecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Delay request present |
| req_ready | output | 1 | Block can take a request (idle) |
| req_delay_us | input | 32 | Requested delay in microseconds |
| abort | input | 1 | Stop the running delay early |
| busy | output | 1 | A delay is running |
| done | output | 1 | One-cycle pulse on compare match |
| stopped | output | 1 | One-cycle pulse when a run is aborted |
| elapsed_us | output | 32 | Time reported at the end of the last run, in microseconds |

## Verification
The bench aims at the range boundaries:
- 65535 against 65536, where a scale chooser that is off by one would pick the wrong prescale and report elapsed times half or double the expected ones.
- A request of 0, where a design without the special case would count a full wrap of the 16-bit counter.
- The all-ones request, which exposes a scale that is not capped at 11 or a compare value that is not saturated.

It also checks the following:
- A request made in the middle of a run must not restart the timer; a timer that restarted would finish late.
- An abort while idle must not produce a `stopped` pulse.
- The abort result must use the count before the current edge. A design that used any other count would be one tick high.

// File: rtl/aot_pkg.sv
package aot_pkg;
  // clock cycles per microsecond expressed as a power of two
  localparam int unsigned AOT_BASE_EXP = 4;
  // largest prescale exponent the prescaler supports
  localparam int unsigned AOT_MAX_EXP  = 15;
  // compare / count register width
  localparam int unsigned AOT_CMP_W    = 16;
  // request and report width
  localparam int unsigned AOT_DLY_W    = 32;
endpackage

// File: rtl/aot_range.sv
// Chooses the smallest extra scale that makes the request fit the compare width.
module aot_range #(
  parameter int unsigned DLY_W = 32,
  parameter int unsigned CMP_W = 16,
  parameter int unsigned MAX_S = 11,
  localparam int unsigned S_W  = $clog2(MAX_S + 1)
) (
  input  logic [DLY_W-1:0] dly_i,
  output logic [S_W-1:0]   scale_o,
  output logic [CMP_W-1:0] cmp_o
);
  logic [MAX_S:0]     fits;
  logic [DLY_W-1:0]   shifted;
  logic               sat;

  for (genvar e = 0; e <= MAX_S; e++) begin : g_fit
    assign fits[e] = ((dly_i >> e) >> CMP_W) == '0;
  end

  always_comb begin
    scale_o = S_W'(MAX_S);
    for (int e = MAX_S; e >= 0; e--) begin
      if (fits[e]) scale_o = S_W'(e);
    end
    sat     = !fits[MAX_S];
    shifted = dly_i >> scale_o;
    cmp_o   = sat ? '1 : shifted[CMP_W-1:0];
  end
endmodule

// File: rtl/aot_tick.sv
// Programmable power-of-two prescaler; wrap_o marks the last cycle of each period.
module aot_tick #(
  parameter int unsigned MAX_EXP = 15,
  localparam int unsigned E_W    = $clog2(MAX_EXP + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           run_i,
  input  logic [E_W-1:0] exp_i,
  output logic           wrap_o
);
  logic [MAX_EXP-1:0] pre_q;
  logic [MAX_EXP-1:0] mask;

  assign mask   = ~({MAX_EXP{1'b1}} << exp_i);
  assign wrap_o = run_i && (pre_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (run_i)  pre_q <= wrap_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/autorange_oneshot.sv
module autorange_oneshot
  import aot_pkg::*;
#(
  parameter int unsigned DLY_W    = AOT_DLY_W,
  parameter int unsigned CMP_W    = AOT_CMP_W,
  parameter int unsigned BASE_EXP = AOT_BASE_EXP,
  parameter int unsigned MAX_EXP  = AOT_MAX_EXP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [DLY_W-1:0] req_delay_us,
  input  logic             abort,
  output logic             busy,
  output logic             done,
  output logic             stopped,
  output logic [DLY_W-1:0] elapsed_us
);
  localparam int unsigned MAX_S = MAX_EXP - BASE_EXP;
  localparam int unsigned S_W   = $clog2(MAX_S + 1);
  localparam int unsigned E_W   = $clog2(MAX_EXP + 1);

  logic [S_W-1:0]   scale_sel, scale_q;
  logic [CMP_W-1:0] cmp_sel, cmp_q, cnt_q;
  logic             accept, wrap, finish;
  logic [E_W-1:0]   exp_q;

  aot_range #(.DLY_W(DLY_W), .CMP_W(CMP_W), .MAX_S(MAX_S)) i_range (
    .dly_i   (req_delay_us),
    .scale_o (scale_sel),
    .cmp_o   (cmp_sel)
  );

  assign exp_q = E_W'(BASE_EXP) + E_W'(scale_q);

  aot_tick #(.MAX_EXP(MAX_EXP)) i_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept),
    .run_i  (busy),
    .exp_i  (exp_q),
    .wrap_o (wrap)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign finish    = (cmp_q == '0) ||
                     (wrap && ({1'b0, cnt_q} + 1'b1 == {1'b0, cmp_q}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      stopped    <= 1'b0;
      elapsed_us <= '0;
      scale_q    <= '0;
      cmp_q      <= '0;
      cnt_q      <= '0;
    end else begin
      done    <= 1'b0;
      stopped <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        scale_q <= scale_sel;
        cmp_q   <= cmp_sel;
        cnt_q   <= '0;
      end else if (busy) begin
        if (abort) begin
          busy       <= 1'b0;
          stopped    <= 1'b1;
          elapsed_us <= DLY_W'(cnt_q) << scale_q;
        end else if (finish) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          elapsed_us <= DLY_W'(cmp_q) << scale_q;
        end else if (wrap) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aot_checker.sv
module aot_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic abort,
  input logic busy,
  input logic done,
  input logic stopped
);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && stopped));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> !stopped);
  a_r4_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r7_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> ($past(busy) && $past(abort) && !busy));
  a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req_valid) && $past(req_ready)));
  a_r8_idle_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && abort) |=> !stopped);
endmodule

bind autorange_oneshot aot_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .abort     (abort),
  .busy      (busy),
  .done      (done),
  .stopped   (stopped)
);

// File: tb/test_autorange_oneshot.sv
`timescale 1ns/1ps
module test_autorange_oneshot;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_delay_us = '0;
  logic        abort = 1'b0;
  logic        busy, done, stopped;
  logic [31:0] elapsed_us;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  autorange_oneshot i_autorange_oneshot (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_delay_us(req_delay_us), .abort(abort), .busy(busy), .done(done),
    .stopped(stopped), .elapsed_us(elapsed_us)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference model
  bit     m_busy = 0, m_done = 0, m_stop = 0;
  longint m_el = 0, m_k = 0, m_s = 0, m_cmp = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_stop = 0; m_el = 0;
    end else begin
      m_done = 0; m_stop = 0;
      if (!m_busy) begin
        if (req_valid) begin
          longint d;
          d = longint'(req_delay_us);
          m_s = 0;
          while ((d >> m_s) > 65535 && m_s < 11) m_s++;
          m_cmp = ((d >> m_s) > 65535) ? 65535 : (d >> m_s);
          m_k = 0;
          m_busy = 1;
        end
      end else if (abort) begin
        m_busy = 0; m_stop = 1;
        m_el = (m_k >> (4 + m_s)) << m_s;
      end else begin
        m_k++;
        if (m_cmp == 0 || m_k == (m_cmp << (4 + m_s))) begin
          m_busy = 0; m_done = 1;
          m_el = m_cmp << m_s;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 ready", req_ready, !m_busy);
      check("R4 busy", busy, m_busy);
      check("R4 done", done, m_done);
      check("R7 stopped", stopped, m_stop);
      check("R9 elapsed", elapsed_us, m_el);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 190000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cycles);
      finish_run();
    end
  end

  // returns edges from accepting edge to the edge that shows done
  task automatic run_delay(input logic [31:0] d, input int exp_edges,
                           input bit poke, input string tag);
    int n = 0;
    @(negedge clk);
    req_delay_us = d; req_valid = 1'b1;
    do begin
      @(negedge clk);
      n++;
      req_valid = (poke && n == 20);
      if (poke && n == 20) req_delay_us = 32'd1;
    end while (!done && n < 100000);
    check(tag, n - 1, exp_edges);
    @(negedge clk);
    check("R10 done pulse", done, 0);
  endtask

  // abort sampled after (w-1) counted edges
  task automatic run_abort(input logic [31:0] d, input int w,
                           input longint exp_el, input string tag);
    @(negedge clk);
    req_delay_us = d; req_valid = 1'b1;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check({tag, " stopped"}, stopped, 1);
    check({tag, " elapsed"}, elapsed_us, exp_el);
    check("R10 exclusive", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 stopped", stopped, 0);
    check("R1 elapsed", elapsed_us, 0);
    check("R1 ready", req_ready, 1);
    rst_n = 1'b1;

    run_delay(32'd1, 16, 0, "R4 delay1");
    check("R9 elapsed1", elapsed_us, 1);
    run_delay(32'd0, 1, 0, "R5 zero");
    check("R9 elapsed0", elapsed_us, 0);
    run_delay(32'd5, 80, 1, "R2 busy request ignored");
    check("R9 elapsed5", elapsed_us, 5);
    run_abort(32'd65535, 101, 6, "R3 s0");
    run_abort(32'd65536, 1001, 62, "R3 s1");
    run_abort(32'd3, 21, 1, "R7 abort");
    run_abort(32'hFFFF_FFFF, 70001, 4096, "R6 saturate");

    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check("R8 idle abort stopped", stopped, 0);
    check("R8 idle abort elapsed", elapsed_us, 4096);
    check("R8 idle abort busy", busy, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule